// File: doc/BRIEF.md
# Memory-Window Bus Front End

This block is the host-side half of a bridge that makes a serial memory look like ordinary memory to a processor. It is a 32-bit Wishbone B4 slave that owns one window of the address map. The window has a fixed base and a power-of-two size, and the base is aligned to that size. Any host access that falls inside the window and carries a legal byte-select mask becomes exactly one request to a downstream memory engine. The request holds the direction, the byte offset in the memory, the data size and the write data aligned to the low lanes. The block then waits for the engine's completion strobe and closes the bus transfer with a single-cycle acknowledge. It can also close the transfer at once with a single-cycle error when the mask is not supported.

The front end works with classic hosts, which hold strobe until the response, and with pipelined hosts, which raise strobe for one cycle only. Addresses outside the window get no response at all, so another slave can claim them. If the host drops its cycle signal while the engine is still busy, the request is withdrawn and nothing is returned. An asynchronous active-low reset and a synchronous active-low reset each bring the block back to idle.

Top module: `memwin_front`

## Requirements
- R1: While either reset is active, and on the cycle after it is released, `wb_ack`, `wb_err` and `req_valid` are low. Asserting the asynchronous reset clears them immediately.
- R2: A transfer is accepted on a rising clock edge where the block is idle and `wb_cyc`, `wb_stb` and a window hit are all high. For a legal mask, `req_valid` is high from the next cycle and stays high, with every request field held constant, until the engine's `eng_done` is sampled or the host drops `wb_cyc`. `req_write` equals `wb_we`.
- R3: `req_offset` is the host address minus `BASE_ADDR`, kept to the window width, with its two low bits replaced by the index of the lowest set bit of `wb_sel` (lane 0 is the lowest memory address).
- R4: `req_size` is 2 for a four-lane mask, 1 for a two-lane mask and 0 for a one-lane mask; code 3 never appears. `req_wdata` is `wb_dat_w` shifted right by eight times the lane index, with zeros filled in at the top.
- R5: Only these masks are legal. A read must use 1111. A write may use 1111, 1100, 0011, 0001, 0010, 0100 or 1000. Any other in-window access raises `wb_err` for exactly one cycle, in the cycle after acceptance, and raises neither `wb_ack` nor `req_valid`.
- R6: When `eng_done` is sampled high while a request is pending and `wb_cyc` is high, `wb_ack` is high for exactly one cycle, in the next cycle. At the same time `wb_dat_r` holds the `eng_rdata` value sampled with `eng_done`.
- R7: A pipelined host that holds `wb_stb` high only on the accepting edge gets the same request and response as a classic host.
- R8: An access whose address lies outside [BASE_ADDR, BASE_ADDR+WIN_BYTES) produces no acknowledge, no error and no request.
- R9: If `wb_cyc` is low on an edge while a request is pending, `req_valid` is low from the next cycle. No acknowledge follows, even if `eng_done` pulses afterwards.
- R10: Holding `srst_n` low for one edge during a pending request drops `req_valid`, and the block then accepts a new transfer normally.
- R11: Each accepted transfer yields exactly one request and one response. The block does not accept a second transfer during the response cycle, even though a classic host still holds its strobe high then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| srst_n | input | 1 | Synchronous reset, active low |
| wb_adr | input | 32 | Host byte address |
| wb_dat_w | input | 32 | Host write data |
| wb_dat_r | output | 32 | Read data returned to host |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_sel | input | 4 | Byte-lane select |
| wb_stb | input | 1 | Strobe |
| wb_cyc | input | 1 | Bus cycle active |
| wb_ack | output | 1 | Successful completion, one cycle |
| wb_err | output | 1 | Error completion, one cycle |
| req_valid | output | 1 | Request pending for the engine |
| req_write | output | 1 | Request direction, 1 = write |
| req_offset | output | OFS_W | Memory byte offset of the first lane |
| req_size | output | 2 | 0 byte, 1 half-word, 2 word |
| req_wdata | output | 32 | Write data, first byte in bits 7:0 |
| eng_done | input | 1 | Engine completion strobe |
| eng_rdata | input | 32 | Engine read data, valid with eng_done |

## Verification
The properties assume that the engine raises `eng_done` only as a single-cycle strobe while a request is pending. They also assume that the host changes its request fields only between transfers, never while one is in progress. The bench engine model follows this: it strobes `eng_done` once after a programmed delay, and it pulses it outside a request only in the abandonment test. The host tasks set address, data, mask and direction before raising `wb_cyc` and leave them alone until the response or the timeout. The sweep covers every mask in both directions, in classic and pipelined form.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } xfer_size_e;

   typedef struct packed {
      logic       legal;
      logic [1:0] lane;
      xfer_size_e size;
   } lane_info_t;

endpackage

// File: rtl/memwin_seldec.sv
module memwin_seldec
   import memwin_pkg::*;
(
   input  logic       we,
   input  logic [3:0] sel,
   output lane_info_t info
);
   always_comb begin
      info = '{legal: 1'b0, lane: 2'd0, size: SZ_WORD};
      unique case (sel)
         4'b1111: info = '{legal: 1'b1,        lane: 2'd0, size: SZ_WORD};
         4'b1100: info = '{legal: we,          lane: 2'd2, size: SZ_HALF};
         4'b0011: info = '{legal: we,          lane: 2'd0, size: SZ_HALF};
         4'b0001: info = '{legal: we,          lane: 2'd0, size: SZ_BYTE};
         4'b0010: info = '{legal: we,          lane: 2'd1, size: SZ_BYTE};
         4'b0100: info = '{legal: we,          lane: 2'd2, size: SZ_BYTE};
         4'b1000: info = '{legal: we,          lane: 2'd3, size: SZ_BYTE};
         default: info = '{legal: 1'b0,        lane: 2'd0, size: SZ_WORD};
      endcase
   end
endmodule

// File: rtl/memwin_adec.sv
module memwin_adec #(
   parameter logic [31:0] BASE_ADDR = 32'hF000_0000,
   parameter int          OFS_W     = 16
) (
   input  logic [31:0]      adr,
   output logic             hit,
   output logic [OFS_W-1:0] win_ofs
);
   logic [31:0] diff;
   assign diff = adr - BASE_ADDR;

   generate
      if (OFS_W >= 32) begin : g_full
         assign hit     = 1'b1;
         assign win_ofs = diff[OFS_W-1:0];
      end else begin : g_part
         assign hit     = (diff[31:OFS_W] == '0);
         assign win_ofs = diff[OFS_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
   import memwin_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             srst_n,
   input  logic             wb_cyc,
   input  logic             wb_stb,
   input  logic             wb_we,
   input  logic [31:0]      wb_dat_w,
   input  logic             hit,
   input  logic [OFS_W-1:0] win_ofs,
   input  lane_info_t       info,
   input  logic             eng_done,
   input  logic [31:0]      eng_rdata,
   output logic             wb_ack,
   output logic             wb_err,
   output logic [31:0]      wb_dat_r,
   output logic             req_valid,
   output logic             req_write,
   output logic [OFS_W-1:0] req_offset,
   output xfer_size_e       req_size,
   output logic [31:0]      req_wdata
);
   typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} state_e;
   state_e st;

   logic             take;
   logic [OFS_W-1:0] ofs_n;
   logic [31:0]      wdat_n;

   assign take   = (st == ST_IDLE) && wb_cyc && wb_stb && hit;
   assign ofs_n  = (win_ofs & ~OFS_W'(3)) | OFS_W'(info.lane);
   assign wdat_n = wb_dat_w >> {info.lane, 3'b000};

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st         <= ST_IDLE;
         wb_ack     <= 1'b0;
         wb_err     <= 1'b0;
         wb_dat_r   <= '0;
         req_valid  <= 1'b0;
         req_write  <= 1'b0;
         req_offset <= '0;
         req_size   <= SZ_WORD;
         req_wdata  <= '0;
      end else if (!srst_n) begin
         st         <= ST_IDLE;
         wb_ack     <= 1'b0;
         wb_err     <= 1'b0;
         req_valid  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (take) begin
                  if (info.legal) begin
                     st         <= ST_BUSY;
                     req_valid  <= 1'b1;
                     req_write  <= wb_we;
                     req_offset <= ofs_n;
                     req_size   <= info.size;
                     req_wdata  <= wdat_n;
                  end else begin
                     st     <= ST_RESP;
                     wb_err <= 1'b1;
                  end
               end
            end
            ST_BUSY: begin
               if (!wb_cyc) begin
                  st        <= ST_IDLE;
                  req_valid <= 1'b0;
               end else if (eng_done) begin
                  st        <= ST_RESP;
                  req_valid <= 1'b0;
                  wb_ack    <= 1'b1;
                  wb_dat_r  <= eng_rdata;
               end
            end
            default: begin
               st     <= ST_IDLE;
               wb_ack <= 1'b0;
               wb_err <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/memwin_front.sv
module memwin_front
   import memwin_pkg::*;
#(
   parameter logic [31:0]     BASE_ADDR = 32'hF000_0000,
   parameter longint unsigned WIN_BYTES = 65536,
   localparam int             OFS_W     = $clog2(WIN_BYTES)
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             srst_n,
   input  logic [31:0]      wb_adr,
   input  logic [31:0]      wb_dat_w,
   output logic [31:0]      wb_dat_r,
   input  logic             wb_we,
   input  logic [3:0]       wb_sel,
   input  logic             wb_stb,
   input  logic             wb_cyc,
   output logic             wb_ack,
   output logic             wb_err,
   output logic             req_valid,
   output logic             req_write,
   output logic [OFS_W-1:0] req_offset,
   output logic [1:0]       req_size,
   output logic [31:0]      req_wdata,
   input  logic             eng_done,
   input  logic [31:0]      eng_rdata
);
   generate
      if ((WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_chk_pow2
         $error("WIN_BYTES must be a power of two");
      end
      if (WIN_BYTES < 4 || WIN_BYTES > 64'h1_0000_0000) begin : g_chk_range
         $error("WIN_BYTES must lie between 4 and 2^32");
      end
      if ((BASE_ADDR & 32'(WIN_BYTES - 1)) != 0) begin : g_chk_align
         $error("BASE_ADDR must be aligned to WIN_BYTES");
      end
   endgenerate

   logic             hit;
   logic [OFS_W-1:0] win_ofs;
   lane_info_t       info;
   xfer_size_e       size_q;

   memwin_adec #(.BASE_ADDR(BASE_ADDR), .OFS_W(OFS_W)) u_adec (
      .adr     (wb_adr),
      .hit     (hit),
      .win_ofs (win_ofs)
   );

   memwin_seldec u_sel (
      .we   (wb_we),
      .sel  (wb_sel),
      .info (info)
   );

   memwin_ctrl #(.OFS_W(OFS_W)) u_ctrl (
      .clk        (clk),
      .arst_n     (arst_n),
      .srst_n     (srst_n),
      .wb_cyc     (wb_cyc),
      .wb_stb     (wb_stb),
      .wb_we      (wb_we),
      .wb_dat_w   (wb_dat_w),
      .hit        (hit),
      .win_ofs    (win_ofs),
      .info       (info),
      .eng_done   (eng_done),
      .eng_rdata  (eng_rdata),
      .wb_ack     (wb_ack),
      .wb_err     (wb_err),
      .wb_dat_r   (wb_dat_r),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_offset (req_offset),
      .req_size   (size_q),
      .req_wdata  (req_wdata)
   );

   assign req_size = size_q;
endmodule

// File: rtl/memwin_chk.sv
module memwin_chk #(
   parameter longint unsigned WIN_BYTES = 65536,
   localparam int             OFS_W     = $clog2(WIN_BYTES)
) (
   input logic             clk,
   input logic             arst_n,
   input logic             srst_n,
   input logic             wb_cyc,
   input logic             wb_ack,
   input logic             wb_err,
   input logic             req_valid,
   input logic             req_write,
   input logic [OFS_W-1:0] req_offset,
   input logic [1:0]       req_size,
   input logic [31:0]      req_wdata,
   input logic             eng_done
);
   a_r6_ack_single: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      wb_ack |=> !wb_ack);

   a_r5_err_single: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      wb_err |=> !wb_err);

   a_r5_ack_err_excl: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      !(wb_ack && wb_err));

   a_r5_err_no_req: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      wb_err |-> !req_valid);

   a_r6_ack_after_done: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      wb_ack |-> $past(req_valid && eng_done && wb_cyc));

   a_r2_req_hold: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      (req_valid && wb_cyc && !eng_done) |=>
         (req_valid && $stable(req_offset) && $stable(req_size)
          && $stable(req_wdata) && $stable(req_write)));

   a_r9_abort: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      (req_valid && !wb_cyc) |=> (!req_valid && !wb_ack));

   a_r4_size_code: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      req_valid |-> (req_size != 2'd3));

   a_r11_idle_after_resp: assert property (@(posedge clk) disable iff (!arst_n || !srst_n)
      (wb_ack || wb_err) |=> !req_valid);
endmodule

bind memwin_front memwin_chk #(.WIN_BYTES(WIN_BYTES)) u_chk (
   .clk        (clk),
   .arst_n     (arst_n),
   .srst_n     (srst_n),
   .wb_cyc     (wb_cyc),
   .wb_ack     (wb_ack),
   .wb_err     (wb_err),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_offset (req_offset),
   .req_size   (req_size),
   .req_wdata  (req_wdata),
   .eng_done   (eng_done)
);

// File: tb/sim_memwin_front.sv
`timescale 1ns/1ps
module sim_memwin_front;
   localparam logic [31:0]     BASE = 32'h0001_0300;
   localparam longint unsigned WINB = 256;
   localparam int              OW   = 8;

   logic        clk = 1'b0;
   logic        arst_n = 1'b0, srst_n = 1'b1;
   logic [31:0] wb_adr = '0, wb_dat_w = '0;
   logic [31:0] wb_dat_r;
   logic        wb_we = 1'b0, wb_stb = 1'b0, wb_cyc = 1'b0;
   logic [3:0]  wb_sel = '0;
   logic        wb_ack, wb_err, req_valid, req_write;
   logic [OW-1:0] req_offset;
   logic [1:0]  req_size;
   logic [31:0] req_wdata;
   logic        eng_done = 1'b0;
   logic [31:0] eng_rdata = '0;

   memwin_front #(.BASE_ADDR(BASE), .WIN_BYTES(WINB)) u0 (
      .clk(clk), .arst_n(arst_n), .srst_n(srst_n),
      .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
      .wb_we(wb_we), .wb_sel(wb_sel), .wb_stb(wb_stb), .wb_cyc(wb_cyc),
      .wb_ack(wb_ack), .wb_err(wb_err),
      .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
      .req_size(req_size), .req_wdata(req_wdata),
      .eng_done(eng_done), .eng_rdata(eng_rdata)
   );

   always #4 clk = ~clk;

   int  n_chk = 0, n_fail = 0;
   int  ack_cnt = 0, err_cnt = 0, req_cnt = 0;
   bit  rv_d = 1'b0;
   bit  finished = 1'b0;
   int  eng_delay = 0, eng_cnt = 0;
   bit  eng_hold = 1'b0, eng_force = 1'b0;
   logic [OW-1:0] cap_ofs;
   logic [1:0]    cap_size;
   logic [31:0]   cap_wdata;
   logic          cap_write;

   function automatic logic [31:0] pat(input logic [OW-1:0] o);
      return {8'hC3, o, ~o, 8'h5A};
   endfunction

   // monitor and engine model, both on the falling edge
   always @(negedge clk) begin
      if (wb_ack) ack_cnt++;
      if (wb_err) err_cnt++;
      if (req_valid && !rv_d) begin
         req_cnt++;
         cap_ofs = req_offset; cap_size = req_size;
         cap_wdata = req_wdata; cap_write = req_write;
      end
      rv_d = req_valid;
      if (req_valid && !eng_hold) begin
         if (eng_cnt >= eng_delay) begin
            eng_done = 1'b1; eng_rdata = pat(req_offset); eng_cnt = 0;
         end else begin
            eng_done = 1'b0; eng_cnt++;
         end
      end else begin
         eng_done = eng_force; eng_cnt = 0;
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [31:0] a, input bit w, input logic [3:0] s,
                       input logic [31:0] d, input bit pipe, input int dly);
      int a0, e0, r0, ones, ln;
      bit seen, inwin, legal;
      logic [31:0] dr, exp_w;
      eng_delay = dly;
      a0 = ack_cnt; e0 = err_cnt; r0 = req_cnt;
      wb_adr = a; wb_we = w; wb_sel = s; wb_dat_w = d;
      wb_cyc = 1'b1; wb_stb = 1'b1;
      seen = 1'b0; dr = '0;
      for (int k = 0; k < 40 && !seen; k++) begin
         step();
         if (pipe) wb_stb = 1'b0;
         if (wb_ack || wb_err) begin seen = 1'b1; dr = wb_dat_r; end
      end
      wb_cyc = 1'b0; wb_stb = 1'b0;
      repeat (4) step();
      ones = $countones(s);
      ln = 0;
      for (int b = 3; b >= 0; b--) if (s[b]) ln = b;
      inwin = (a >= BASE) && (a < BASE + 32'(WINB));
      legal = (s == 4'hF) || (w && (s == 4'hC || s == 4'h3 || ones == 1));
      if (!inwin) begin
         chk((ack_cnt - a0) == 0 && (err_cnt - e0) == 0 && (req_cnt - r0) == 0,
             "R8 out-of-window silent", 32'(ack_cnt - a0 + err_cnt - e0 + req_cnt - r0), 0);
      end else if (!legal) begin
         chk((err_cnt - e0) == 1, "R5 single error pulse", 32'(err_cnt - e0), 1);
         chk((ack_cnt - a0) == 0 && (req_cnt - r0) == 0, "R5 no ack no request",
             32'(ack_cnt - a0 + req_cnt - r0), 0);
      end else begin
         chk((ack_cnt - a0) == 1 && (err_cnt - e0) == 0,
             pipe ? "R7 pipelined single ack" : "R6 single ack", 32'(ack_cnt - a0), 1);
         chk((req_cnt - r0) == 1, "R11 one request", 32'(req_cnt - r0), 1);
         chk(cap_write == w, "R2 direction", 32'(cap_write), 32'(w));
         chk(cap_ofs == OW'({a[7:2], 2'b00} + ln), "R3 offset", 32'(cap_ofs),
             32'({a[7:2], 2'b00} + ln));
         chk(cap_size == 2'((ones == 4) ? 2 : (ones == 2) ? 1 : 0), "R4 size",
             32'(cap_size), 32'((ones == 4) ? 2 : (ones == 2) ? 1 : 0));
         exp_w = d >> (8 * ln);
         chk(cap_wdata == exp_w, "R4 write data", cap_wdata, exp_w);
         if (!w) chk(dr == pat(cap_ofs), "R6 read data", dr, pat(cap_ofs));
      end
   endtask

   initial begin
      int a0;
      // R1 reset state
      repeat (2) step();
      chk(!wb_ack && !wb_err && !req_valid, "R1 during async reset",
          {29'd0, wb_ack, wb_err, req_valid}, 0);
      arst_n = 1'b1;
      step();
      chk(!wb_ack && !wb_err && !req_valid, "R1 after release",
          {29'd0, wb_ack, wb_err, req_valid}, 0);

      // sweep: every mask, both directions, both host styles, several addresses
      for (int ai = 0; ai < 4; ai++) begin
         for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 2; w++) begin
               for (int p = 0; p < 2; p++) begin
                  xfer(BASE + 32'(ai * 68 + (s & 3)), w[0], 4'(s),
                       32'hA1B2C3D4 ^ 32'(s * 32'h01010101 + ai), p[0], (s + ai) % 4);
               end
            end
         end
      end
      // window edges
      xfer(BASE - 32'd4, 1'b0, 4'hF, 0, 1'b0, 1);
      xfer(BASE + 32'(WINB), 1'b1, 4'h1, 32'h55, 1'b1, 1);
      xfer(32'hF001_0300, 1'b0, 4'hF, 0, 1'b0, 1);
      xfer(BASE + 32'(WINB) - 32'd1, 1'b0, 4'hF, 0, 1'b0, 2);

      // R9 abandonment
      eng_hold = 1'b1;
      a0 = ack_cnt;
      wb_adr = BASE + 32'h40; wb_we = 1'b0; wb_sel = 4'hF; wb_cyc = 1'b1; wb_stb = 1'b1;
      repeat (3) step();
      chk(req_valid, "R2 request pending", 32'(req_valid), 1);
      wb_cyc = 1'b0; wb_stb = 1'b0;
      step();
      chk(!req_valid, "R9 request withdrawn", 32'(req_valid), 0);
      eng_hold = 1'b0; eng_force = 1'b1;
      step();
      eng_force = 1'b0;
      repeat (5) step();
      chk((ack_cnt - a0) == 0, "R9 no ack after late done", 32'(ack_cnt - a0), 0);

      // R10 synchronous reset during pending request
      eng_hold = 1'b1;
      wb_adr = BASE + 32'h10; wb_we = 1'b1; wb_sel = 4'h3; wb_dat_w = 32'h1234_5678;
      wb_cyc = 1'b1; wb_stb = 1'b1;
      repeat (2) step();
      wb_stb = 1'b0;
      srst_n = 1'b0;
      step();
      chk(!req_valid && !wb_ack, "R10 sync reset clears", {30'd0, req_valid, wb_ack}, 0);
      srst_n = 1'b1; wb_cyc = 1'b0;
      eng_hold = 1'b0;
      repeat (2) step();
      xfer(BASE + 32'h20, 1'b0, 4'hF, 0, 1'b0, 0);

      // R1 asynchronous reset mid-transfer
      eng_hold = 1'b1;
      wb_adr = BASE + 32'h30; wb_we = 1'b0; wb_sel = 4'hF; wb_cyc = 1'b1; wb_stb = 1'b1;
      repeat (2) step();
      arst_n = 1'b0;
      #1;
      chk(!req_valid, "R1 async clear", 32'(req_valid), 0);
      wb_cyc = 1'b0; wb_stb = 1'b0; eng_hold = 1'b0;
      step();
      arst_n = 1'b1;
      step();
      xfer(BASE + 32'h34, 1'b1, 4'h8, 32'hDEAD_BEEF, 1'b1, 3);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1200000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog R11 actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule